// File: doc/BRIEF.md
# Keyboard and Display Register Interface

This block sits between a processor's load/store bus and two character devices: a keyboard that delivers 8-bit codes and a display that consumes them. Software sees six word-addressed registers, a data, a status and a control register for each channel. It can poll the ready flags in the status registers, or it can enable a per-channel interrupt request and be told when a channel needs service.

The keyboard side applies no back-pressure. A code offered with `kb_valid` is always taken in the same cycle. If the previous code has not yet been collected, the new code replaces it and a sticky overrun flag records the loss. The display side is a push with a completion signal. A bus write to the display data register sends the character out with a one-cycle `disp_valid` strobe. The channel then reports busy until the display pulses `disp_done`.

A read of either status register returns the flags and then clears them. An interrupt acknowledge also clears the ready flag of its own channel, which withdraws that channel's request.

Top module: `kbd_disp_if`

## Requirements
- R1: After reset the keyboard ready flag (status offset 1, bit 1) and the overrun flag (offset 1, bit 3) are 0. The display ready flag (offset 4, bit 2) is 1. Both enable bits (bit 0 of offsets 2 and 5) are 0. Both interrupt lines and `disp_valid` are low.
- R2: A cycle with `kb_valid` high stores `kb_code` in the keyboard data register, which reads at offset 0 in bits 7:0. From the next cycle, status bit 1 reads 1.
- R3: A read of offset 1 (`bus_rd` high) returns the current flags in the same cycle and clears bits 1 and 3 from the next cycle. A read of offset 0 clears nothing.
- R4: A code that arrives while bit 1 is set overwrites the data register and sets bit 3. Bit 3 stays set until the next read of offset 1.
- R5: A write to offset 3 drives `disp_char` from `bus_wdata[7:0]` with `disp_valid` high for exactly the next cycle. It clears status bit 2 at offset 4 until a `disp_done` pulse sets the bit again.
- R6: A read of offset 4 returns the display flag and clears bit 2 from the next cycle.
- R7: Bit 0 of offset 2 and bit 0 of offset 5 are writable enables that read back. `kbd_irq` is high exactly when the keyboard ready flag and its enable are both 1. `disp_irq` is high exactly when the display ready flag and its enable are both 1.
- R8: A cycle with `kbd_ack` high clears the keyboard ready flag and leaves the data register unchanged. A cycle with `disp_ack` high clears the display ready flag. Either request drops from the next cycle.
- R9: When a clearing event meets a setting event in the same cycle, the setting event wins. A code arriving during a read of offset 1 leaves bit 1 set. A `disp_done` pulse during a read of offset 4 leaves bit 2 set.
- R10: Offsets 6 and 7 read as 0. Bus writes to the two status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; triggers the status clear side effect |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the address |
| kb_valid | input | 1 | Keyboard code present this cycle |
| kb_code | input | CHAR_W | Keyboard code |
| disp_valid | output | 1 | One-cycle character strobe to the display |
| disp_char | output | CHAR_W | Character to the display |
| disp_done | input | 1 | Display has finished the last character |
| kbd_ack | input | 1 | Interrupt acknowledge for the keyboard channel |
| disp_ack | input | 1 | Interrupt acknowledge for the display channel |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
The bench targets the same-cycle collisions of R9. A design that gives priority to the clear would lose a keyboard code that arrives just as software polls, and it would never report a finished display. It also feeds two codes with no read between them, because a design without the sticky overrun flag would drop a character silently. It reads the data register and checks that the ready flag survives, because a clear wired to the wrong address would empty the flag early. It sends characters back to back through a scoreboard, which catches a strobe that lasts two cycles or a character latched from the wrong bits.

// File: rtl/kdi_pkg.sv
package kdi_pkg;
  // Register word offsets
  localparam int unsigned OFF_KDATA = 0;
  localparam int unsigned OFF_KSTAT = 1;
  localparam int unsigned OFF_KCTRL = 2;
  localparam int unsigned OFF_DDATA = 3;
  localparam int unsigned OFF_DSTAT = 4;
  localparam int unsigned OFF_DCTRL = 5;
  // Bit positions decoded by software
  localparam int unsigned BIT_KRDY  = 1;
  localparam int unsigned BIT_KOVR  = 3;
  localparam int unsigned BIT_DRDY  = 2;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned NUM_CHAN  = 2;
  localparam int unsigned CH_KBD    = 0;
  localparam int unsigned CH_DISP   = 1;

  typedef struct packed {
    logic kstat_rd;
    logic dstat_rd;
    logic ddata_wr;
    logic kctrl_wr;
    logic dctrl_wr;
  } kdi_access_t;
endpackage

// File: rtl/kdi_kbd_chan.sv
module kdi_kbd_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_code,
  input  logic              stat_rd,
  input  logic              ack,
  output logic [CHAR_W-1:0] data_q,
  output logic              ready_q,
  output logic              ovr_q
);
  logic ready_d, ovr_d;

  // Arrival wins over both clearing events
  always_comb begin
    ready_d = kb_valid | (ready_q & ~stat_rd & ~ack);
    ovr_d   = (kb_valid & ready_q) | (ovr_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (kb_valid) data_q <= kb_code;
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
    end
  end

  AST_KRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> ready_q); // R2
  AST_KRDY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !kb_valid) |=> !ready_q); // R3
  AST_KOVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && ready_q) |=> (ovr_q && data_q == $past(kb_code))); // R4
  AST_KACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !kb_valid) |=> (!ready_q && $stable(data_q))); // R8
endmodule

// File: rtl/kdi_disp_chan.sv
module kdi_disp_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              stat_rd,
  input  logic              ack,
  input  logic              done,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  output logic              ready_q
);
  logic ready_d;

  // A new write makes the channel busy; done beats read or ack
  always_comb begin
    if (data_wr)   ready_d = 1'b0;
    else if (done) ready_d = 1'b1;
    else           ready_d = ready_q & ~stat_rd & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_char  <= '0;
      ready_q    <= 1'b1;
    end else begin
      disp_valid <= data_wr;
      if (data_wr) disp_char <= wr_char;
      ready_q <= ready_d;
    end
  end

  AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(data_wr)); // R5
  AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !ready_q); // R5
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !data_wr) |=> ready_q); // R9
  AST_DACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done && !data_wr) |=> !ready_q); // R8
endmodule

// File: rtl/kdi_ctrl_bit.sv
module kdi_ctrl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  output logic en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= 1'b0;
    else if (wr) en_q <= wbit;
  end
endmodule

// File: rtl/kbd_disp_if.sv
module kbd_disp_if
  import kdi_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_code,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_done,
  input  logic              kbd_ack,
  input  logic              disp_ack,
  output logic              kbd_irq,
  output logic              disp_irq
);
  localparam logic [ADDR_W-1:0] A_KDATA = ADDR_W'(OFF_KDATA);
  localparam logic [ADDR_W-1:0] A_KSTAT = ADDR_W'(OFF_KSTAT);
  localparam logic [ADDR_W-1:0] A_KCTRL = ADDR_W'(OFF_KCTRL);
  localparam logic [ADDR_W-1:0] A_DDATA = ADDR_W'(OFF_DDATA);
  localparam logic [ADDR_W-1:0] A_DSTAT = ADDR_W'(OFF_DSTAT);
  localparam logic [ADDR_W-1:0] A_DCTRL = ADDR_W'(OFF_DCTRL);

  kdi_access_t acc;
  logic [CHAR_W-1:0] kdata;
  logic k_ready, k_ovr, d_ready;
  logic [NUM_CHAN-1:0] en_q, en_wr;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CHAR_W];

  always_comb begin
    acc.kstat_rd = bus_rd & (bus_addr == A_KSTAT);
    acc.dstat_rd = bus_rd & (bus_addr == A_DSTAT);
    acc.ddata_wr = bus_wr & (bus_addr == A_DDATA);
    acc.kctrl_wr = bus_wr & (bus_addr == A_KCTRL);
    acc.dctrl_wr = bus_wr & (bus_addr == A_DCTRL);
  end

  assign en_wr[CH_KBD]  = acc.kctrl_wr;
  assign en_wr[CH_DISP] = acc.dctrl_wr;

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_ctrl
    kdi_ctrl_bit u_en (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (en_wr[ch]),
      .wbit (bus_wdata[BIT_EN]),
      .en_q (en_q[ch])
    );
  end

  kdi_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
    .clk     (clk),
    .rst_n   (rst_n),
    .kb_valid(kb_valid),
    .kb_code (kb_code),
    .stat_rd (acc.kstat_rd),
    .ack     (kbd_ack),
    .data_q  (kdata),
    .ready_q (k_ready),
    .ovr_q   (k_ovr)
  );

  kdi_disp_chan #(.CHAR_W(CHAR_W)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (acc.ddata_wr),
    .wr_char   (bus_wdata[CHAR_W-1:0]),
    .stat_rd   (acc.dstat_rd),
    .ack       (disp_ack),
    .done      (disp_done),
    .disp_valid(disp_valid),
    .disp_char (disp_char),
    .ready_q   (d_ready)
  );

  assign kbd_irq  = k_ready & en_q[CH_KBD];
  assign disp_irq = d_ready & en_q[CH_DISP];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_KDATA: bus_rdata[CHAR_W-1:0] = kdata;
      A_KSTAT: begin
        bus_rdata[BIT_KRDY] = k_ready;
        bus_rdata[BIT_KOVR] = k_ovr;
      end
      A_KCTRL: bus_rdata[BIT_EN] = en_q[CH_KBD];
      A_DDATA: bus_rdata[CHAR_W-1:0] = disp_char;
      A_DSTAT: bus_rdata[BIT_DRDY] = d_ready;
      A_DCTRL: bus_rdata[BIT_EN] = en_q[CH_DISP];
      default: bus_rdata = '0;
    endcase
  end

  AST_KIRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kctrl_wr && !bus_wdata[BIT_EN]) |=> !kbd_irq); // R7
  AST_DIRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.dctrl_wr && !bus_wdata[BIT_EN]) |=> !disp_irq); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > A_DCTRL) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/kbd_disp_if_bench.sv
module kbd_disp_if_bench;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int CHAR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic kb_valid = 1'b0;
  logic [CHAR_W-1:0] kb_code = '0;
  logic disp_valid;
  logic [CHAR_W-1:0] disp_char;
  logic disp_done = 1'b0, kbd_ack = 1'b0, disp_ack = 1'b0;
  logic kbd_irq, disp_irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [CHAR_W-1:0] exp_q[$];

  always #10 clk = ~clk;

  kbd_disp_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_kbd_disp_if (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_code(kb_code), .disp_valid(disp_valid),
    .disp_char(disp_char), .disp_done(disp_done), .kbd_ack(kbd_ack),
    .disp_ack(disp_ack), .kbd_irq(kbd_irq), .disp_irq(disp_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: a display write also pushes the expected character
  task automatic show(input logic [7:0] c);
    exp_q.push_back(c);
    wr(3, {24'h0, c});
  endtask

  task automatic kb_send(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_code = c;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); disp_done = 1'b1;
    @(negedge clk); disp_done = 1'b0;
  endtask

  // Monitor: every strobe cycle must match the next expected character
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected strobe", 32'(disp_char), 32'hFFFF_FFFF);
      else check("R5 display char", 32'(disp_char), 32'(exp_q.pop_front()));
    end
  end

  task automatic run_tests();
    logic [31:0] d;
    // R1 reset state
    check("R1 kbd_irq", 32'(kbd_irq), 0);
    check("R1 disp_irq", 32'(disp_irq), 0);
    check("R1 disp_valid", 32'(disp_valid), 0);
    rd_chk("R1 kstat", 1, 0);
    rd_chk("R1 kctrl", 2, 0);
    rd_chk("R1 dctrl", 5, 0);
    rd_chk("R1 dstat", 4, 32'h4);
    // R2, R3 receive and clear-on-read
    kb_send(8'h41);
    rd_chk("R2 kdata", 0, 32'h41);
    rd_chk("R3 kstat after data read", 1, 32'h2);
    rd_chk("R3 kstat cleared", 1, 0);
    // R4 overrun
    kb_send(8'h42);
    kb_send(8'h43);
    rd_chk("R4 kdata overwritten", 0, 32'h43);
    rd_chk("R4 kstat overrun", 1, 32'hA);
    rd_chk("R4 overrun cleared", 1, 0);
    // R5, R6 display
    rd_chk("R6 dstat clear", 4, 0);
    pulse_done();
    show(8'h48);
    rd_chk("R5 busy", 4, 0);
    pulse_done();
    rd_chk("R5 done", 4, 32'h4);
    rd_chk("R6 cleared", 4, 0);
    show(8'h69);
    show(8'h21);
    pulse_done();
    // R7 enables and requests
    wr(2, 1);
    rd_chk("R7 kctrl readback", 2, 1);
    kb_send(8'h55);
    check("R7 kbd_irq on", 32'(kbd_irq), 1);
    // R8 acknowledge
    @(negedge clk); kbd_ack = 1'b1;
    @(negedge clk); kbd_ack = 1'b0;
    check("R8 kbd_irq dropped", 32'(kbd_irq), 0);
    rd_chk("R8 kdata kept", 0, 32'h55);
    rd_chk("R8 kstat cleared", 1, 0);
    wr(5, 1);
    rd_chk("R7 dctrl readback", 5, 1);
    check("R7 disp_irq on", 32'(disp_irq), 1);
    @(negedge clk); disp_ack = 1'b1;
    @(negedge clk); disp_ack = 1'b0;
    check("R8 disp_irq dropped", 32'(disp_irq), 0);
    wr(2, 0);
    kb_send(8'h56);
    check("R7 kbd_irq gated", 32'(kbd_irq), 0);
    rd_chk("R7 flag still set", 1, 32'h2);
    // R9 collisions
    @(negedge clk);
    bus_addr = 3'd1; bus_rd = 1'b1; kb_valid = 1'b1; kb_code = 8'h77;
    @(negedge clk);
    bus_rd = 1'b0; kb_valid = 1'b0;
    rd_chk("R9 arrival beats read", 1, 32'h2);
    rd_chk("R9 then clears", 1, 0);
    @(negedge clk);
    bus_addr = 3'd4; bus_rd = 1'b1; disp_done = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; disp_done = 1'b0;
    rd_chk("R9 done beats read", 4, 32'h4);
    // R10 unmapped and read-only status
    rd_chk("R10 offset6", 6, 0);
    rd_chk("R10 offset7", 7, 0);
    wr(1, 32'hFF);
    rd_chk("R10 kstat write ignored", 1, 0);
    wr(4, 0);
    pulse_done();
    rd_chk("R10 dstat write ignored", 4, 32'h4);
    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", 32'(exp_q.size()), 0);
    rd(0, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        check("watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule